// File: doc/BRIEF.md
# Keyed-Enable Watchdog Timer

This block is a memory-mapped watchdog for a single clock domain. An up-counter advances on every tick of an optional power-of-two prescaler. When it passes all-ones it emits a one-cycle reset pulse, latches an overflow interrupt and reloads itself from a load register. Software keeps the system alive by writing the trigger register with a value that differs from its current contents, which reloads the counter early. Loading the bitwise inverse of N gives roughly N ticks before timeout.

The counter only starts or stops after an ordered pair of key words is written to the key register. A key state machine with three states tracks this. `KEY_IDLE` goes to `KEY_ARM_HALF` on 0xBBBB and to `KEY_DISARM_HALF` on 0xAAAA. `KEY_ARM_HALF` returns to `KEY_IDLE`, setting the run flag if the word was 0x4444. `KEY_DISARM_HALF` returns to `KEY_IDLE`, clearing the run flag if the word was 0x5555. Any other word leaves the run flag unchanged.

Writes to control, counter, load, trigger, key and delay are posted. Each one takes effect a fixed three cycles after the bus write, and a per-register pending bit is raised for that interval so software can poll before writing again. A self-clearing soft reset returns every register to its reset value.

Top module: `keyed_wdog`

## Requirements
- R1: After `rst_n` is released, all readable registers read 0 except status bit 0 (1), and `wdt_reset_o` and `irq_o` are 0.
- R2: A posted write takes effect on the third rising edge after the edge that samples it. The pending register at 0x34 holds the matching bit at 1 until then. Bit positions: 0 control, 1 counter, 2 load, 3 trigger, 4 key, 5 delay.
- R3: The counter starts after the key register receives 0xBBBB then 0x4444, and stops after 0xAAAA then 0x5555. A stopped counter holds its value.
- R4: If the first word of a sequence is followed by any other value, the sequence returns to idle and the run state is unchanged. A second word (0x4444 or 0x5555) with no preceding first word is ignored.
- R5: On a tick where the counter equals all-ones, the counter reloads from the load register and `wdt_reset_o` pulses for one cycle.
- R6: Control bit 5 enables the prescaler and bits 4:2 hold an exponent E, so the counter advances once every 2^E cycles. Other control bits read 0.
- R7: Writing the trigger register with a value different from its current contents reloads the counter from the load register. Writing an equal value has no effect on the counter.
- R8: A write to the counter register sets the count directly, and reads of it return the live count.
- R9: Interrupt bit 0 is the overflow event and bit 1 is the delay event. 0x54 is raw status and 0x58 is raw AND enable; writing 1 to a bit of either clears it. Writing 1s to 0x5C sets enable bits, writing 1s to 0x60 clears them, and both read back the enable. `irq_o` is high when any masked bit is set.
- R10: Writing 1 to bit 1 of 0x10 starts a soft reset. The bit reads 1 and status bit 0 reads 0 for one cycle. Then both revert, and all registers return to their reset values.
- R11: Register offsets: 0x10 system control, 0x14 status, 0x24 control, 0x28 counter, 0x2C load, 0x30 trigger, 0x34 pending, 0x44 delay, 0x48 key (16 bits read back), 0x54 raw IRQ, 0x58 masked IRQ, 0x5C enable set, 0x60 enable clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counter and bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe, sampled on the rising edge |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| wdt_reset_o | output | 1 | One-cycle pulse on overflow |
| irq_o | output | 1 | Level interrupt, OR of masked status |

## Verification
The key machine is driven with four patterns: a correct start pair, a correct stop pair, a stop pair broken by a stray word, and a lone second word. Sampling the count on two successive cycles after each pattern tells running apart from stopped. The count is driven with the prescaler off, at exponent 1 and at exponent 2. The measured advance over a fixed window tells each division ratio apart. Trigger writes of an equal value and of a new value distinguish reload-on-change from reload-on-any-write. An overflow measured from a known start tells the tick count apart from an off-by-one.

// File: rtl/kw_pkg.sv
package kw_pkg;
    localparam logic [7:0] A_SYSC = 8'h10;
    localparam logic [7:0] A_STAT = 8'h14;
    localparam logic [7:0] A_CTRL = 8'h24;
    localparam logic [7:0] A_CNT  = 8'h28;
    localparam logic [7:0] A_LOAD = 8'h2C;
    localparam logic [7:0] A_TRIG = 8'h30;
    localparam logic [7:0] A_PEND = 8'h34;
    localparam logic [7:0] A_DLY  = 8'h44;
    localparam logic [7:0] A_KEY  = 8'h48;
    localparam logic [7:0] A_RAW  = 8'h54;
    localparam logic [7:0] A_MSK  = 8'h58;
    localparam logic [7:0] A_ENS  = 8'h5C;
    localparam logic [7:0] A_ENC  = 8'h60;

    localparam int P_CTRL = 0;
    localparam int P_CNT  = 1;
    localparam int P_LOAD = 2;
    localparam int P_TRIG = 3;
    localparam int P_KEY  = 4;
    localparam int P_DLY  = 5;
    localparam int NPOST  = 6;

    localparam logic [15:0] KEY_ARM_A    = 16'hBBBB;
    localparam logic [15:0] KEY_ARM_B    = 16'h4444;
    localparam logic [15:0] KEY_DISARM_A = 16'hAAAA;
    localparam logic [15:0] KEY_DISARM_B = 16'h5555;

    typedef enum logic [1:0] {
        KEY_IDLE        = 2'd0,
        KEY_ARM_HALF    = 2'd1,
        KEY_DISARM_HALF = 2'd2
    } key_state_t;

    function automatic logic [7:0] post_off(input int idx);
        case (idx)
            P_CTRL:  post_off = A_CTRL;
            P_CNT:   post_off = A_CNT;
            P_LOAD:  post_off = A_LOAD;
            P_TRIG:  post_off = A_TRIG;
            P_KEY:   post_off = A_KEY;
            default: post_off = A_DLY;
        endcase
    endfunction
endpackage

// File: rtl/kw_posted.sv
module kw_posted #(
    parameter int W   = 32,
    parameter int LAT = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    output logic         pend,
    output logic         apply,
    output logic [W-1:0] data
);
    localparam int CW = $clog2(LAT + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            data  <= '0;
        end else if (clr) begin
            cnt_q <= '0;
            data  <= '0;
        end else if (wr) begin
            cnt_q <= CW'(LAT);
            data  <= wdata;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign pend  = (cnt_q != '0);
    assign apply = (cnt_q == CW'(1)) && !wr;

    assert_pend_on_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !clr) |=> pend);
endmodule

// File: rtl/kw_key_fsm.sv
module kw_key_fsm
    import kw_pkg::*;
#(
    parameter int KW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          apply,
    input  logic [KW-1:0] key,
    output logic          running
);
    key_state_t state_q, state_d;
    logic       run_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= KEY_IDLE;
            running <= 1'b0;
        end else if (clr) begin
            state_q <= KEY_IDLE;
            running <= 1'b0;
        end else begin
            state_q <= state_d;
            running <= run_d;
        end
    end

    always_comb begin
        state_d = state_q;
        run_d   = running;
        if (apply) begin
            unique case (state_q)
                KEY_IDLE: begin
                    if (key == KW'(KEY_ARM_A))         state_d = KEY_ARM_HALF;
                    else if (key == KW'(KEY_DISARM_A)) state_d = KEY_DISARM_HALF;
                end
                KEY_ARM_HALF: begin
                    state_d = KEY_IDLE;
                    if (key == KW'(KEY_ARM_B)) run_d = 1'b1;
                end
                KEY_DISARM_HALF: begin
                    state_d = KEY_IDLE;
                    if (key == KW'(KEY_DISARM_B)) run_d = 1'b0;
                end
                default: state_d = KEY_IDLE;
            endcase
        end
    end

    assert_start_after_arm_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(running) |-> ($past(state_q) == KEY_ARM_HALF));
    assert_lone_second_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == KEY_IDLE && apply && !clr) |=> (running == $past(running)));
endmodule

// File: rtl/kw_counter.sv
module kw_counter #(
    parameter int W  = 32,
    parameter int PW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          run,
    input  logic          pre_en,
    input  logic [PW-1:0] ptv,
    input  logic          ld,
    input  logic [W-1:0]  ld_val,
    input  logic          reload,
    input  logic [W-1:0]  reload_val,
    output logic [W-1:0]  cnt,
    output logic          ovf
);
    localparam int DIVW = 1 << PW;

    logic [DIVW-1:0] pre_q, mask;
    logic            tick, at_max;

    always_comb begin
        for (int i = 0; i < DIVW; i++) begin
            mask[i] = pre_en && (i < 32'(ptv));
        end
    end

    assign tick   = ((pre_q & mask) == mask);
    assign at_max = (cnt == {W{1'b1}});

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q <= '0;
            cnt   <= '0;
            ovf   <= 1'b0;
        end else if (clr) begin
            pre_q <= '0;
            cnt   <= '0;
            ovf   <= 1'b0;
        end else begin
            pre_q <= pre_q + 1'b1;
            ovf   <= !ld && !reload && run && tick && at_max;
            if (ld)                cnt <= ld_val;
            else if (reload)       cnt <= reload_val;
            else if (run && tick)  cnt <= at_max ? reload_val : cnt + 1'b1;
        end
    end

    assert_ovf_needs_run_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |-> $past(run));
    assert_hold_when_stopped_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !ld && !reload && !clr) |=> (cnt == $past(cnt)));
endmodule

// File: rtl/keyed_wdog.sv
module keyed_wdog
    import kw_pkg::*;
#(
    parameter int AW       = 8,
    parameter int DW       = 32,
    parameter int PW       = 3,
    parameter int POST_LAT = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_we,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    output logic          wdt_reset_o,
    output logic          irq_o
);
    localparam int KW = 16;

    logic             srst_q;
    logic [NPOST-1:0] pend, papply;
    logic [DW-1:0]    pdata [NPOST];
    logic [PW+2:0]    ctrl_q;
    logic [DW-1:0]    load_q, trig_q, dly_q, cnt;
    logic [KW-1:0]    key_q;
    logic [1:0]       irq_raw, irq_en;
    logic             running, ovf, trig_reload;

    for (genvar i = 0; i < NPOST; i++) begin : g_post
        kw_posted #(.W(DW), .LAT(POST_LAT)) u_post (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (srst_q),
            .wr    (bus_we && (bus_addr == AW'(post_off(i)))),
            .wdata (bus_wdata),
            .pend  (pend[i]),
            .apply (papply[i]),
            .data  (pdata[i])
        );
    end

    assign trig_reload = papply[P_TRIG] && (pdata[P_TRIG] != trig_q);

    kw_key_fsm #(.KW(KW)) u_key (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (srst_q),
        .apply   (papply[P_KEY]),
        .key     (pdata[P_KEY][KW-1:0]),
        .running (running)
    );

    kw_counter #(.W(DW), .PW(PW)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (srst_q),
        .run        (running),
        .pre_en     (ctrl_q[PW+2]),
        .ptv        (ctrl_q[PW+1:2]),
        .ld         (papply[P_CNT]),
        .ld_val     (pdata[P_CNT]),
        .reload     (trig_reload),
        .reload_val (load_q),
        .cnt        (cnt),
        .ovf        (ovf)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            srst_q  <= 1'b0;
            ctrl_q  <= '0;
            load_q  <= '0;
            trig_q  <= '0;
            dly_q   <= '0;
            key_q   <= '0;
            irq_raw <= '0;
            irq_en  <= '0;
        end else if (srst_q) begin
            srst_q  <= 1'b0;
            ctrl_q  <= '0;
            load_q  <= '0;
            trig_q  <= '0;
            dly_q   <= '0;
            key_q   <= '0;
            irq_raw <= '0;
            irq_en  <= '0;
        end else begin
            if (bus_we && bus_addr == AW'(A_SYSC)) srst_q <= bus_wdata[1];
            if (papply[P_CTRL]) ctrl_q <= {pdata[P_CTRL][PW+2:2], 2'b00};
            if (papply[P_LOAD]) load_q <= pdata[P_LOAD];
            if (papply[P_TRIG]) trig_q <= pdata[P_TRIG];
            if (papply[P_DLY])  dly_q  <= pdata[P_DLY];
            if (papply[P_KEY])  key_q  <= pdata[P_KEY][KW-1:0];
            if (bus_we && bus_addr == AW'(A_ENS)) irq_en <= irq_en | bus_wdata[1:0];
            if (bus_we && bus_addr == AW'(A_ENC)) irq_en <= irq_en & ~bus_wdata[1:0];
            irq_raw <= ((bus_we && (bus_addr == AW'(A_RAW) || bus_addr == AW'(A_MSK)))
                        ? (irq_raw & ~bus_wdata[1:0]) : irq_raw) | {1'b0, ovf};
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            AW'(A_SYSC): bus_rdata[1] = srst_q;
            AW'(A_STAT): bus_rdata[0] = !srst_q;
            AW'(A_CTRL): bus_rdata[PW+2:0] = ctrl_q;
            AW'(A_CNT):  bus_rdata = cnt;
            AW'(A_LOAD): bus_rdata = load_q;
            AW'(A_TRIG): bus_rdata = trig_q;
            AW'(A_PEND): bus_rdata[NPOST-1:0] = pend;
            AW'(A_DLY):  bus_rdata = dly_q;
            AW'(A_KEY):  bus_rdata[KW-1:0] = key_q;
            AW'(A_RAW):  bus_rdata[1:0] = irq_raw;
            AW'(A_MSK):  bus_rdata[1:0] = irq_raw & irq_en;
            AW'(A_ENS),
            AW'(A_ENC):  bus_rdata[1:0] = irq_en;
            default:     bus_rdata = '0;
        endcase
    end

    assign wdt_reset_o = ovf;
    assign irq_o       = |(irq_raw & irq_en);

    assert_srst_selfclear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        srst_q |=> !srst_q);
    assert_raw_on_ovf_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !srst_q) |=> irq_raw[0]);
endmodule

// File: tb/keyed_wdog_tb_top.sv
module keyed_wdog_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = 8'h0;
    logic [31:0] bus_wdata = 32'h0;
    logic [31:0] bus_rdata;
    logic        wdt_reset_o, irq_o;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    keyed_wdog dut_i (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .wdt_reset_o(wdt_reset_o), .irq_o(irq_o)
    );

    // {address, write data, expected readback}
    localparam logic [71:0] VEC [6] = '{
        {8'h2C, 32'h1234_5678, 32'h1234_5678},
        {8'h44, 32'hCAFE_0001, 32'hCAFE_0001},
        {8'h28, 32'h0000_ABCD, 32'h0000_ABCD},
        {8'h30, 32'h0000_0055, 32'h0000_0055},
        {8'h48, 32'hABCD_1234, 32'h0000_1234},
        {8'h24, 32'hFFFF_FFFF, 32'h0000_003C}
    };

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic wait_idle();
        logic [31:0] p;
        for (int i = 0; i < 20; i++) begin
            rd(8'h34, p);
            if (p == 32'h0) break;
            @(negedge clk);
        end
    endtask

    task automatic wpost(input logic [7:0] a, input logic [31:0] d);
        wr(a, d);
        wait_idle();
    endtask

    task automatic is_running(input string req, input logic exp);
        logic [31:0] c0, c1;
        rd(8'h28, c0);
        @(negedge clk);
        rd(8'h28, c1);
        chk(req, {31'h0, c1 != c0}, {31'h0, exp});
    endtask

    initial begin
        for (int i = 0; i < 100000; i++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog expired got 1 expected 0");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] v, c0;
        int k;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset values
        rd(8'h28, v); chk("R1 counter", v, 0);
        rd(8'h2C, v); chk("R1 load", v, 0);
        rd(8'h14, v); chk("R1 status", v, 1);
        rd(8'h34, v); chk("R1 pending", v, 0);
        chk("R1 outputs", {30'h0, wdt_reset_o, irq_o}, 0);

        // R11 register map, walked from the vector table
        foreach (VEC[i]) begin
            wpost(VEC[i][71:64], VEC[i][63:32]);
            rd(VEC[i][71:64], v);
            chk("R11 readback", v, VEC[i][31:0]);
        end
        wpost(8'h24, 32'h0);

        // R2 posted latency and pending bit 2 for the load register
        wr(8'h2C, 32'h0000_0777);
        for (int e = 0; e < 3; e++) begin
            rd(8'h34, v); chk("R2 pending held", v, 32'h4);
            rd(8'h2C, v); chk("R2 old load", v, 32'h1234_5678);
            @(negedge clk);
        end
        rd(8'h34, v); chk("R2 pending cleared", v, 0);
        rd(8'h2C, v); chk("R2 new load", v, 32'h777);

        // R7 trigger: equal value no reload, new value reloads
        wpost(8'h2C, 32'h100);
        wpost(8'h28, 32'h5);
        wpost(8'h30, 32'h55);
        rd(8'h28, v); chk("R7 equal trigger", v, 32'h5);
        wpost(8'h30, 32'h1);
        rd(8'h28, v); chk("R7 new trigger", v, 32'h100);
        wpost(8'h28, 32'h7);
        rd(8'h28, v); chk("R8 direct counter write", v, 32'h7);

        // R4 lone second word does not start
        wpost(8'h48, 32'h4444);
        is_running("R4 lone start word", 1'b0);

        // R3/R5 start and overflow timing
        wpost(8'h2C, 32'hFFFF_FF00);
        wpost(8'h28, 32'hFFFF_FF00);
        wpost(8'h48, 32'hBBBB);
        wr(8'h48, 32'h4444);
        repeat (3) @(negedge clk);
        rd(8'h28, v); chk("R3 start value", v, 32'hFFFF_FF00);
        repeat (5) @(negedge clk);
        rd(8'h28, v); chk("R8 live count", v, 32'hFFFF_FF05);
        k = 5;
        for (int i = 0; i < 300; i++) begin
            if (wdt_reset_o) break;
            @(negedge clk);
            k++;
        end
        chk("R5 ticks to overflow", k, 256);
        rd(8'h28, v); chk("R5 reload on overflow", v, 32'hFFFF_FF00);
        @(negedge clk);
        chk("R5 pulse one cycle", {31'h0, wdt_reset_o}, 0);

        // R9 interrupts
        rd(8'h54, v); chk("R9 raw overflow", v, 32'h1);
        chk("R9 irq masked off", {31'h0, irq_o}, 0);
        wr(8'h5C, 32'h1);
        chk("R9 irq on", {31'h0, irq_o}, 1);
        rd(8'h58, v); chk("R9 masked status", v, 32'h1);
        wr(8'h60, 32'h1);
        chk("R9 enable clear", {31'h0, irq_o}, 0);
        rd(8'h54, v); chk("R9 raw kept", v, 32'h1);
        wr(8'h5C, 32'h1);
        wr(8'h54, 32'h1);
        rd(8'h54, v); chk("R9 raw w1c", v, 0);
        chk("R9 irq after w1c", {31'h0, irq_o}, 0);

        // R4 broken stop sequence keeps running
        wpost(8'h48, 32'hAAAA);
        wpost(8'h48, 32'h1234);
        wpost(8'h48, 32'h5555);
        is_running("R4 broken stop", 1'b1);

        // R6 prescaler exponent 1 then 2
        wpost(8'h24, 32'h24);
        rd(8'h28, c0); repeat (8) @(negedge clk); rd(8'h28, v);
        chk("R6 divide by 2", v - c0, 4);
        wpost(8'h24, 32'h28);
        rd(8'h28, c0); repeat (16) @(negedge clk); rd(8'h28, v);
        chk("R6 divide by 4", v - c0, 4);
        wpost(8'h24, 32'h0);

        // R3 stop
        wpost(8'h48, 32'hAAAA);
        wpost(8'h48, 32'h5555);
        is_running("R3 stopped", 1'b0);

        // R10 soft reset
        wr(8'h10, 32'h2);
        rd(8'h10, v); chk("R10 srst bit set", v, 32'h2);
        rd(8'h14, v); chk("R10 status busy", v, 0);
        @(negedge clk);
        rd(8'h10, v); chk("R10 srst cleared", v, 0);
        rd(8'h14, v); chk("R10 status done", v, 1);
        rd(8'h2C, v); chk("R10 load reset", v, 0);
        rd(8'h5C, v); chk("R10 enable reset", v, 0);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule